// File: doc/BRIEF.md
# Sprite Overlay Buffer

The block holds a single fixed-size sprite image of 8-bit pixels in on-chip RAM and lays it over a video raster. A one-time image load comes in over a ready/valid byte stream whose source also reports how many bytes it currently holds. After a load request, the block waits until that count covers a whole image. It then accepts one byte per cycle until the image is complete and raises a completion flag.

On every pixel clock the block compares the raster's horizontal and vertical counters against a programmable sprite origin. It produces a hit flag and a pixel value, both one cycle behind the counters, which matches the RAM read latency. Reading for display does not disturb the stored image, so the same sprite can be shown frame after frame. The RAM is organised as words of several pixel lanes, which shortens the word count.

Top module: `sprite_overlay`

## Requirements
- R1: While reset is asserted and in the first cycles after its release, `st_ready`, `img_ready`, `spr_hit` and `spr_pix` are all 0.
- R2: After a load request, `st_ready` stays 0 until a clock edge samples `st_avail` at or above SPR_W*SPR_H. It is 1 from the cycle after that edge.
- R3: While copying, `st_ready` is 1 on every cycle. A byte is taken on each edge where `st_valid` and `st_ready` are both 1. Exactly SPR_W*SPR_H bytes are taken, and `st_ready` is 0 from the cycle after the last one.
- R4: `img_ready` is 1 from the cycle after the last accepted byte. The k-th accepted byte, counting from 0, is the pixel at row k/SPR_W and column k mod SPR_W.
- R5: A load request clears `img_ready` and drops `st_ready` on the following cycle. This holds in the middle of a copy too, and the next copy starts again with byte 0.
- R6: `spr_hit` is 1 exactly one cycle after the counters satisfy both 0 <= h_cnt-org_x < SPR_W and 0 <= v_cnt-org_y < SPR_H. The differences are taken without wrap-around, so h_cnt < org_x is outside.
- R7: When the hit holds and a load has completed, `spr_pix` is the stored pixel at row v_cnt-org_y and column h_cnt-org_x, with the same one-cycle delay.
- R8: `spr_pix` is 0 whenever `spr_hit` is 0, and whenever `img_ready` was 0 in the previous cycle.
- R9: Display reads never change the stored image. Bytes presented while `st_ready` is 0 are ignored. The image reads back unchanged on repeated sweeps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_req | input | 1 | One-cycle request to start a new image load |
| st_data | input | PIX_W | Incoming pixel byte |
| st_valid | input | 1 | Byte on `st_data` is valid |
| st_ready | output | 1 | Block accepts a byte this cycle |
| st_avail | input | CNT_W | Number of bytes the source holds |
| h_cnt | input | CW | Raster horizontal counter |
| v_cnt | input | CW | Raster vertical counter |
| org_x | input | CW | Sprite left column on screen |
| org_y | input | CW | Sprite top line on screen |
| spr_hit | output | 1 | Delayed in-sprite flag |
| spr_pix | output | PIX_W | Delayed pixel value, 0 outside or before load |
| img_ready | output | 1 | A complete image is stored |

## Verification
The bench builds the block with a 13 x 7 sprite and four pixel lanes per RAM word. This gives a 91-pixel image whose last RAM word is only partly used. A whole load, an aborted load and full-window sweeps then take a few thousand cycles instead of tens of thousands. The odd width puts row ends at every lane position, so the row-major address, the lane select and the partial tail word are all exercised. An origin near the top of the counter range checks that the hit test does not wrap around.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // Load sequencer states
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_WAIT = 2'd1,
    LD_COPY = 2'd2
  } ld_state_e;

endpackage

// File: rtl/spr_load_ctrl.sv
module spr_load_ctrl
  import spr_pkg::*;
#(
  parameter int NPIX  = 10000,
  parameter int AW    = 14,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] in_avail,
  output logic             in_ready,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             done
);

  localparam logic [AW-1:0]    LAST_ADDR = AW'(NPIX - 1);
  localparam logic [CNT_W-1:0] NEED      = CNT_W'(NPIX);

  ld_state_e     state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;
  logic          take;

  // a request in the same cycle wins over the handshake
  assign in_ready = (state_q == LD_COPY) && !req;
  assign take     = in_ready && in_valid;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    done_d  = done_q;
    if (req) begin
      state_d = LD_WAIT;
      addr_d  = '0;
      done_d  = 1'b0;
    end else begin
      unique case (state_q)
        LD_WAIT: begin
          if (in_avail >= NEED) state_d = LD_COPY;
        end
        LD_COPY: begin
          if (take) begin
            if (addr_q == LAST_ADDR) begin
              state_d = LD_IDLE;
              addr_d  = '0;
              done_d  = 1'b1;
            end else begin
              addr_d = addr_q + AW'(1);
            end
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req || take) addr_q <= addr_d;
      if (req || take) done_q <= done_d;
    end
  end

  assign wr_en   = take;
  assign wr_addr = addr_q;
  assign done    = done_q;

  // copy begins only after the source reported a full image
  p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(in_avail >= NEED));

  p_addr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= LAST_ADDR));

  p_last_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == LAST_ADDR) |=> (done && !in_ready));

  p_req_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (!done && !in_ready));

  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req) |=> done);

endmodule

// File: rtl/spr_pixel_ram.sv
module spr_pixel_ram #(
  parameter int NPIX  = 10000,
  parameter int PIX_W = 8,
  parameter int LANES = 4,   // pixels per word, power of two
  parameter int AW    = 14
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_data
);

  localparam int WORDS  = (NPIX + LANES - 1) / LANES;
  localparam int WA_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int WORD_W = LANES * PIX_W;

  logic [WORD_W-1:0] mem [WORDS];

  logic [AW-1:0]     wr_word_full, rd_word_full;
  logic [WA_W-1:0]   wr_word, rd_word;
  logic [LSEL_W-1:0] wr_lane, rd_lane;
  logic [WORD_W-1:0] rd_word_q;
  logic [LSEL_W-1:0] rd_lane_q;

  assign wr_word_full = wr_addr / AW'(LANES);
  assign rd_word_full = rd_addr / AW'(LANES);
  assign wr_word      = WA_W'(wr_word_full);
  assign rd_word      = WA_W'(rd_word_full);
  assign wr_lane      = LSEL_W'(wr_addr % AW'(LANES));
  assign rd_lane      = LSEL_W'(rd_addr % AW'(LANES));

  // byte-lane write into the addressed word
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_word][wr_lane*PIX_W +: PIX_W] <= wr_data;
  end

  // registered read: one cycle latency
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_word_q <= mem[rd_word];
      rd_lane_q <= rd_lane;
    end
  end

  generate
    if (LANES == 1) begin : g_single
      assign rd_data = rd_word_q[PIX_W-1:0];
    end else begin : g_multi
      logic [PIX_W-1:0] lane_pix [LANES];
      for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_pix[g] = rd_word_q[g*PIX_W +: PIX_W];
      end
      assign rd_data = lane_pix[rd_lane_q];
    end
  endgenerate

endmodule

// File: rtl/spr_window.sv
module spr_window #(
  parameter int SPR_W = 100,
  parameter int SPR_H = 100,
  parameter int CW    = 11,
  parameter int AW    = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] hpos,
  input  logic [CW-1:0] vpos,
  input  logic [CW-1:0] ox,
  input  logic [CW-1:0] oy,
  input  logic          loaded,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          hit_q,
  output logic          show_q
);

  logic [CW-1:0] dx, dy;
  logic          in_h, in_v, hit;
  logic          hit_d, show_d;

  assign dx   = hpos - ox;
  assign dy   = vpos - oy;
  assign in_h = (hpos >= ox) && (dx < CW'(SPR_W));
  assign in_v = (vpos >= oy) && (dy < CW'(SPR_H));
  assign hit  = in_h && in_v;

  // row-major offset inside the sprite
  assign rd_addr = AW'(dy) * AW'(SPR_W) + AW'(dx);
  assign rd_en   = hit && loaded;

  assign hit_d  = hit;
  assign show_d = hit && loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      show_q <= 1'b0;
    end else begin
      hit_q  <= hit_d;
      show_q <= show_d;
    end
  end

  p_hit_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> ($past(hpos) >= $past(ox) && $past(vpos) >= $past(oy)));

  p_show_in_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    show_q |-> hit_q);

endmodule

// File: rtl/sprite_overlay.sv
module sprite_overlay #(
  parameter int SPR_W = 100,
  parameter int SPR_H = 100,
  parameter int PIX_W = 8,
  parameter int LANES = 4,
  parameter int CNT_W = 16,
  parameter int CW    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_req,
  input  logic [PIX_W-1:0] st_data,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [CNT_W-1:0] st_avail,
  input  logic [CW-1:0]    h_cnt,
  input  logic [CW-1:0]    v_cnt,
  input  logic [CW-1:0]    org_x,
  input  logic [CW-1:0]    org_y,
  output logic             spr_hit,
  output logic [PIX_W-1:0] spr_pix,
  output logic             img_ready
);

  localparam int NPIX = SPR_W * SPR_H;
  localparam int AW   = (NPIX > 1) ? $clog2(NPIX) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;
  logic [PIX_W-1:0] rd_data;
  logic             hit_q, show_q;
  logic             loaded;

  spr_load_ctrl #(
    .NPIX (NPIX),
    .AW   (AW),
    .CNT_W(CNT_W)
  ) u_load (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req     (ld_req),
    .in_valid(st_valid),
    .in_avail(st_avail),
    .in_ready(st_ready),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .done    (loaded)
  );

  spr_pixel_ram #(
    .NPIX (NPIX),
    .PIX_W(PIX_W),
    .LANES(LANES),
    .AW   (AW)
  ) u_ram (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(st_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  spr_window #(
    .SPR_W(SPR_W),
    .SPR_H(SPR_H),
    .CW   (CW),
    .AW   (AW)
  ) u_win (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .hpos   (h_cnt),
    .vpos   (v_cnt),
    .ox     (org_x),
    .oy     (org_y),
    .loaded (loaded),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .hit_q  (hit_q),
    .show_q (show_q)
  );

  assign spr_hit   = hit_q;
  assign spr_pix   = show_q ? rd_data : '0;
  assign img_ready = loaded;

  p_blank_outside_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !spr_hit |-> (spr_pix == '0));

  p_blank_unloaded_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(!img_ready) |-> (spr_pix == '0));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!st_ready && !img_ready && !spr_hit));

endmodule

// File: tb/sprite_overlay_bench.sv
module sprite_overlay_bench;

  localparam int W    = 13;
  localparam int H    = 7;
  localparam int PW   = 8;
  localparam int LN   = 4;
  localparam int CNTW = 16;
  localparam int CW   = 11;
  localparam int N    = W * H;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ld_req;
  logic [PW-1:0]   st_data;
  logic            st_valid;
  logic            st_ready;
  logic [CNTW-1:0] st_avail;
  logic [CW-1:0]   h_cnt, v_cnt, org_x, org_y;
  logic            spr_hit;
  logic [PW-1:0]   spr_pix;
  logic            img_ready;

  always #5 clk = ~clk;

  sprite_overlay #(
    .SPR_W(W), .SPR_H(H), .PIX_W(PW), .LANES(LN), .CNT_W(CNTW), .CW(CW)
  ) u_sprite_overlay (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .st_data(st_data),
    .st_valid(st_valid), .st_ready(st_ready), .st_avail(st_avail),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .org_x(org_x), .org_y(org_y),
    .spr_hit(spr_hit), .spr_pix(spr_pix), .img_ready(img_ready)
  );

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  loaded  = 0;
  bit  finished = 0;
  logic [PW-1:0] img [N];

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_hit(int h, int v, int x, int y);
    return (h >= x && h - x < W && v >= y && v - y < H) ? 1 : 0;
  endfunction

  function automatic int exp_pix(int h, int v, int x, int y, bit ld);
    if (exp_hit(h, v, x, y) == 0 || !ld) return 0;
    return int'(img[(v - y) * W + (h - x)]);
  endfunction

  task automatic new_image();
    for (int i = 0; i < N; i++) img[i] = PW'($urandom_range(1, 255));
  endtask

  // drive counters, check the outputs one cycle later
  task automatic probe(int h, int v, int x, int y, string req);
    @(negedge clk);
    h_cnt = CW'(h); v_cnt = CW'(v); org_x = CW'(x); org_y = CW'(y);
    @(negedge clk);
    check(req, "spr_hit", int'(spr_hit), exp_hit(h, v, x, y));
    check(req, "spr_pix", int'(spr_pix), exp_pix(h, v, x, y, loaded));
  endtask

  task automatic pulse_req();
    @(negedge clk);
    st_valid = 1'b0;
    ld_req   = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
    loaded = 0;
    check("R5", "img_ready after request", int'(img_ready), 0);
    check("R5", "st_ready after request", int'(st_ready), 0);
  endtask

  // abort_at < 0: full load
  task automatic do_load(int abort_at);
    int cnt = 0;
    pulse_req();
    // source short by one byte; junk offered must be ignored
    st_avail = CNTW'(N - 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      st_valid = 1'b1;
      st_data  = PW'($urandom);
      check("R2", "st_ready with short count", int'(st_ready), 0);
    end
    @(negedge clk);
    st_valid = 1'b0;
    st_avail = CNTW'(N);
    while (cnt < N) begin
      @(negedge clk);
      check("R3", "st_ready during copy", int'(st_ready), 1);
      if (abort_at >= 0 && cnt == abort_at) break;
      st_valid = ($urandom_range(0, 3) != 0);
      st_data  = st_valid ? img[cnt] : PW'($urandom);
      if (st_valid) cnt++;
    end
    if (abort_at >= 0) begin
      st_valid = 1'b0;
      st_avail = '0;
      pulse_req();
      return;
    end
    @(negedge clk);
    st_valid = 1'b0;
    st_avail = '0;
    check("R3", "st_ready after last byte", int'(st_ready), 0);
    check("R4", "img_ready after last byte", int'(img_ready), 1);
    loaded = 1;
    repeat (3) @(negedge clk);
    check("R3", "st_ready stays low", int'(st_ready), 0);
  endtask

  task automatic sweep(int x, int y, string req);
    for (int v = y - 1; v <= y + H; v++)
      for (int h = x - 1; h <= x + W; h++)
        probe(h, v, x, y, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; ld_req = 1'b0; st_data = '0; st_valid = 1'b0;
    st_avail = '0; h_cnt = '0; v_cnt = '0; org_x = '0; org_y = '0;
    repeat (3) @(negedge clk);
    check("R1", "st_ready in reset", int'(st_ready), 0);
    check("R1", "img_ready in reset", int'(img_ready), 0);
    check("R1", "spr_hit in reset", int'(spr_hit), 0);
    check("R1", "spr_pix in reset", int'(spr_pix), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "st_ready after release", int'(st_ready), 0);
    repeat (4) @(negedge clk);

    // before any load: hit flag works, pixel blank (R8)
    probe(5, 3, 2, 1, "R8");
    probe(1, 3, 2, 1, "R6");

    // aborted load, then full load of a different image (R5, R4)
    new_image();
    do_load(N / 3);
    new_image();
    do_load(-1);

    sweep(9, 4, "R7");
    probe(0, 0, 0, 0, "R4");
    probe(W - 1, H - 1, 0, 0, "R4");
    probe(W, 0, 0, 0, "R6");
    probe(0, H, 0, 0, "R6");
    // origin near top of counter range: no wrap-around
    probe(2047, 2046, 2040, 2043, "R6");
    probe(3, 2045, 2040, 2043, "R6");

    for (int i = 0; i < 300; i++) begin
      int x = $urandom_range(0, 60);
      int y = $urandom_range(0, 40);
      int h, v;
      if ($urandom_range(0, 3) == 0) begin
        h = $urandom_range(0, 127);
        v = $urandom_range(0, 63);
      end else begin
        h = x + $urandom_range(0, W + 4) - 2;
        v = y + $urandom_range(0, H + 4) - 2;
        if (h < 0) h = 0;
        if (v < 0) v = 0;
      end
      probe(h, v, x, y, (exp_hit(h, v, x, y) != 0) ? "R7" : "R8");
    end

    // repeated display reads leave the image intact
    sweep(30, 20, "R9");

    // a new request blanks the output again
    pulse_req();
    probe(4, 2, 0, 0, "R8");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule